// File: doc/BRIEF.md
# Sequential Horner Polynomial Evaluator

This block computes the value of a polynomial of fixed degree at a signed input `x`. The coefficients sit in a table that is fixed when the block is built. It uses one multiply-add datapath in nested (Horner) form. A reset loads the accumulator with the highest-order coefficient. After that, each clock performs one step: the accumulator is multiplied by `x` and the next lower coefficient is added. When the constant term has been added, `ready` rises.

All values are signed two's-complement numbers of `WIDTH` bits. Every product is cut back to its low `WIDTH` bits, and overflow is not flagged. To start an evaluation, the user holds `rst` high, presents `x`, releases `rst`, and waits for `ready`. `x` must stay stable until `ready` is high. `result` has no meaning while `ready` is low.

Top module: `horner_eval`

## Requirements
- R1: While `rst` is high at a rising edge, `ready` is low after that edge.
- R2: The coefficient table is a packed vector in which the slice `[k*WIDTH +: WIDTH]` holds the coefficient of x^k. When `ready` is high, `result` equals (((a_n·x + a_{n-1})·x + …)·x + a_0).
- R3: Each step computes the low `WIDTH` bits of acc·x, adds the coefficient, and wraps modulo 2^WIDTH. The final value therefore equals a Horner model that uses the same wraparound.
- R4: For a degree `DEGREE` ≥ 1, `ready` rises after exactly `DEGREE` rising edges with `rst` low.
- R5: Once `ready` is high, it stays high and `result` stays frozen until the next reset, even if `x` changes.
- R6: Asserting `rst` in the middle of an evaluation drops `ready` and restarts the evaluation from the highest coefficient.
- R7: With `DEGREE` = 0, `ready` rises after the first rising edge with `rst` low, and `result` equals a_0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; starts a new evaluation |
| x | input | WIDTH | Signed evaluation point |
| result | output | WIDTH | Signed polynomial value, valid while `ready` is high |
| ready | output | 1 | High once the evaluation has finished |

## Verification
The bench runs the cubic 3x³−2x²−4x+5 at x = 4, 7, 15 and −9, and at a large x whose powers wrap. A reversed coefficient order or a dropped truncation would show up as a wrong value. The bench counts edges from reset release to `ready`, so a sequencer that is off by one is reported. It changes `x` after completion to catch an accumulator that keeps stepping, and resets in the middle of a run to catch stale state. A second instance of degree zero catches a sequencer that never finishes or that reads an index outside the table.

// File: rtl/horner_pkg.sv
package horner_pkg;
  // Width of a counter that must hold values 0..max_val (at least one bit).
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction
endpackage

// File: rtl/horner_coef_rom.sv
module horner_coef_rom #(
  parameter int WIDTH  = 32,
  parameter int DEGREE = 3,
  parameter int IW     = 2,
  parameter logic [(DEGREE+1)*WIDTH-1:0] TABLE = '0
) (
  input  logic [IW-1:0]           idx,
  output logic signed [WIDTH-1:0] coef,
  output logic signed [WIDTH-1:0] coef_top
);
  localparam int ENTRIES = DEGREE + 1;

  logic signed [WIDTH-1:0] tbl [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_unpack
    assign tbl[k] = TABLE[k*WIDTH +: WIDTH];
  end

  always_comb begin
    coef = tbl[0];
    for (int k = 0; k < ENTRIES; k++) begin
      if (int'(idx) == k) coef = tbl[k];
    end
  end

  assign coef_top = tbl[DEGREE];
endmodule

// File: rtl/horner_seq.sv
module horner_seq #(
  parameter int DEGREE = 3,
  parameter int CW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] remain,
  output logic [CW-1:0] coef_idx,
  output logic          step,
  output logic          ready
);
  localparam logic [CW-1:0] START = CW'(DEGREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= START;
      ready  <= 1'b0;
    end else if (!ready) begin
      if (remain <= CW'(1)) ready <= 1'b1;
      if (remain != '0) remain <= remain - CW'(1);
    end
  end

  assign step     = !rst && !ready && (remain != '0);
  assign coef_idx = (remain == '0) ? '0 : remain - CW'(1);

  // R1: reset clears completion
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !ready);
  // R5: completion is sticky until reset
  a_r5_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  // R4: the countdown moves by exactly one per working cycle
  a_r4_countdown: assert property (@(posedge clk) disable iff (rst)
    (!ready && remain != '0) |=> (remain == $past(remain) - CW'(1)));
  // R4: completion only once every coefficient has been consumed
  a_r4_done_empty: assert property (@(posedge clk) disable iff (rst)
    ready |-> remain == '0);
endmodule

// File: rtl/horner_mac.sv
module horner_mac #(
  parameter int WIDTH = 32
) (
  input  logic                    clk,
  input  logic                    load,
  input  logic                    step,
  input  logic signed [WIDTH-1:0] load_val,
  input  logic signed [WIDTH-1:0] x,
  input  logic signed [WIDTH-1:0] coef,
  output logic signed [WIDTH-1:0] acc
);
  localparam int PW = 2 * WIDTH;

  logic signed [PW-1:0]    prod;
  logic signed [WIDTH-1:0] prod_lo;

  assign prod    = PW'(acc) * PW'(x);
  assign prod_lo = prod[WIDTH-1:0];

  always_ff @(posedge clk) begin
    if (load)      acc <= load_val;
    else if (step) acc <= prod_lo + coef;
  end
endmodule

// File: rtl/horner_eval.sv
module horner_eval #(
  parameter int WIDTH  = 32,
  parameter int DEGREE = 3,
  parameter logic [(DEGREE+1)*WIDTH-1:0] COEFS =
    {32'sd3, -32'sd2, -32'sd4, 32'sd5}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [WIDTH-1:0] x,
  output logic signed [WIDTH-1:0] result,
  output logic                    ready
);
  localparam int CW = horner_pkg::cnt_width(DEGREE);

  logic [CW-1:0]           remain;
  logic [CW-1:0]           coef_idx;
  logic                    step;
  logic signed [WIDTH-1:0] coef;
  logic signed [WIDTH-1:0] coef_top;

  horner_coef_rom #(.WIDTH(WIDTH), .DEGREE(DEGREE), .IW(CW), .TABLE(COEFS)) u_rom (
    .idx(coef_idx), .coef(coef), .coef_top(coef_top)
  );

  horner_seq #(.DEGREE(DEGREE), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .remain(remain), .coef_idx(coef_idx),
    .step(step), .ready(ready)
  );

  horner_mac #(.WIDTH(WIDTH)) u_mac (
    .clk(clk), .load(rst), .step(step), .load_val(coef_top),
    .x(x), .coef(coef), .acc(result)
  );

  // R5: result frozen once complete
  a_r5_result_frozen: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(result));
  // R6: after a reset the accumulator restarts at the top coefficient
  a_r6_restart_top: assert property (@(posedge clk)
    rst |=> (result == coef_top));
endmodule

// File: tb/horner_eval_test.sv
module horner_eval_test;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [W-1:0] x = '0;
  logic signed [W-1:0] y3, y0;
  logic rdy3, rdy0;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  horner_eval #(.WIDTH(W), .DEGREE(3),
    .COEFS({32'sd3, -32'sd2, -32'sd4, 32'sd5})) uut (
    .clk(clk), .rst(rst), .x(x), .result(y3), .ready(rdy3));

  horner_eval #(.WIDTH(W), .DEGREE(0), .COEFS(32'sd7)) uut_const (
    .clk(clk), .rst(rst), .x(x), .result(y0), .ready(rdy0));

  function automatic logic signed [W-1:0] model(input logic signed [W-1:0] xv);
    logic signed [W-1:0] c [4];
    logic signed [W-1:0] a;
    c[0] = 5; c[1] = -4; c[2] = -2; c[3] = 3;
    a = c[3];
    for (int k = 2; k >= 0; k--) a = W'(a * xv) + c[k];
    return a;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic signed [W-1:0] xv);
    @(negedge clk); rst = 1'b1; x = xv;
    @(negedge clk);
    check("R1", rdy3, 0);
    rst = 1'b0;
  endtask

  task automatic eval_case(input logic signed [W-1:0] xv, input string req);
    int cyc;
    start(xv);
    cyc = 0;
    for (int i = 0; i < 10 && !rdy3; i++) begin
      @(negedge clk); cyc++;
    end
    check("R4", cyc, 3);
    check(req, y3, model(xv));
  endtask

  task automatic known_values;
    eval_case(32'sd4,  "R2"); check("R2", y3, 149);
    eval_case(32'sd7,  "R2"); check("R2", y3, 908);
    eval_case(32'sd15, "R2"); check("R2", y3, 9620);
    eval_case(-32'sd9, "R2"); check("R2", y3, -2308);
  endtask

  task automatic wrap_case;
    eval_case(32'sd100003, "R3");
    eval_case(-32'sd77777, "R3");
  endtask

  task automatic hold_case;
    logic signed [W-1:0] kept;
    eval_case(32'sd5, "R2");
    kept = y3;
    x = 32'sd11;
    repeat (4) @(negedge clk);
    check("R5", rdy3, 1);
    check("R5", y3, kept);
  endtask

  task automatic restart_case;
    start(32'sd3);
    @(negedge clk);
    rst = 1'b1; x = 32'sd2;
    @(negedge clk);
    check("R6", rdy3, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", rdy3, 1);
    check("R6", y3, model(32'sd2));
  endtask

  task automatic const_case;
    start(32'sd9);
    check("R7", rdy0, 0);
    @(negedge clk);
    check("R7", rdy0, 1);
    check("R7", y0, 7);
  endtask

  initial begin
    fork
      begin
        known_values();
        wrap_case();
        hold_case();
        restart_case();
        const_case();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule